// File: doc/BRIEF.md
# Serial Register Write Port

This block is a slave control port that accepts register writes over three wires: a serial data line, a serial bit clock, and an active-low framing line that also acts as the commit strobe. All three wires are brought into the system clock domain through two-flop synchronisers. Edge detectors then turn them into single-cycle events. The port runs on its own, with no timing link to any audio data path.

While the framing line is low, each rising bit-clock edge shifts one data bit into a 16-bit word, most significant bit first. When the framing line returns high, the word is checked. The frame is accepted only if exactly sixteen bits arrived and the leading bit is zero. An accepted frame writes its data byte into the addressed mode register. The block then drives a one-cycle write strobe, together with the index and data that were committed, for downstream logic. The register bank covers a contiguous window of indices, set by parameters. All registers are presented in parallel on one flat output bus.

Top module: `ctl3w_port`

## Requirements
- R1: During and after reset, the register at offset k of the window (index BASE_IDX+k) holds 0x40 + 3*k, modulo 256. wr_stb, wr_idx and wr_data read 0.
- R2: A frame is shifted most significant bit first, sampled on the rising edge of the bit clock while the framing line is low. Bit 15 must be 0, bits 14..8 give the 7-bit index, and bits 7..0 give the data byte. A valid frame to an index in the window writes the byte into that register.
- R3: The write is visible on the register output, and wr_stb pulses, within 8 system clock cycles after the framing line returns high.
- R4: A frame that ends after fewer than 16 bits is discarded: no register changes and no strobe.
- R5: A frame that ends after more than 16 bits is discarded, even if its last 16 bits would form a valid word.
- R6: A frame whose bit 15 is 1 is discarded.
- R7: A frame whose index lies outside BASE_IDX .. BASE_IDX+NUM_REGS-1 changes no register and raises no strobe.
- R8: wr_stb is high for exactly one cycle per accepted write, with wr_idx and wr_data equal to the committed index and byte. Both hold their values between strobes.
- R9: Bit-clock edges and data changes while the framing line is high have no effect, and the next valid frame is still decoded correctly.
- R10: An accepted write changes only the addressed register; every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_din | input | 1 | Serial data line |
| ser_bclk | input | 1 | Serial bit clock |
| ser_latch_n | input | 1 | Active-low framing line; its rising edge commits a frame |
| reg_flat | output | NUM_REGS*8 | All mode registers; offset k sits at bits 8k+7..8k |
| wr_stb | output | 1 | One-cycle pulse for each accepted write |
| wr_idx | output | 7 | Index of the last accepted write |
| wr_data | output | 8 | Data byte of the last accepted write |

## Verification
The bench targets the framing edges. It sends 15-bit and 17-bit frames; the 17-bit frame is built so that its final sixteen bits form a valid word. A port that counts bytes or keeps a sliding window would then commit a write that should never happen. It also sends a frame with the leading bit set, and indices one below and one above the window, which a sloppy range decode would alias onto a real register. Stray bit clocks while the framing line is high would corrupt the next frame in a design that shifts regardless of framing. Strobe pulses are counted, so a stretched or missing strobe shows up as a count mismatch.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int FRAME_BITS = 16;
  localparam int IDX_W      = 7;
  localparam int DATA_W     = 8;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

  function automatic logic frame_lead(input logic [FRAME_BITS-1:0] w);
    return w[FRAME_BITS-1];
  endfunction

  function automatic logic [IDX_W-1:0] frame_idx(input logic [FRAME_BITS-1:0] w);
    return w[DATA_W +: IDX_W];
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(input logic [FRAME_BITS-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // Power-on value of the register at window offset k.
  function automatic logic [DATA_W-1:0] rst_value(input int k);
    return DATA_W'(8'h40 + 3 * k);
  endfunction

  function automatic logic idx_hit(input logic [IDX_W-1:0] idx, input int base, input int num);
    return (int'(idx) >= base) && (int'(idx) < base + num);
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RST_VAL;
        else        pipe <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= pipe[STAGES-1];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/ctl3w_deframe.sv
module ctl3w_deframe
  import ctl3w_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_s,
  input  logic             bclk_rise,
  input  logic             latch_lvl,
  input  logic             latch_fall,
  input  logic             latch_rise,
  output logic             cmt_vld,
  output wr_cmd_t          cmt,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam int CNT_MAX = FRAME_BITS + 1;

  logic [FRAME_BITS-1:0] shreg;
  logic                  frame_good;

  // Exact length and a zero leading bit are both required.
  assign frame_good = (int'(bit_cnt) == FRAME_BITS) && !frame_lead(shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (latch_fall) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!latch_lvl && bclk_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], din_s};
      if (int'(bit_cnt) != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_vld <= 1'b0;
      cmt     <= '0;
    end else begin
      cmt_vld <= latch_rise && frame_good;
      if (latch_rise && frame_good) begin
        cmt.idx  <= frame_idx(shreg);
        cmt.data <= frame_data(shreg);
      end
    end
  end
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BASE_IDX = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmt_vld,
  input  wr_cmd_t                    cmt,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic                       wr_stb,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [DATA_W-1:0]          wr_data
);
  logic bank_hit;
  assign bank_hit = cmt_vld && idx_hit(cmt.idx, BASE_IDX, NUM_REGS);

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE_IDX + k);
      logic [DATA_W-1:0] val;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          val <= rst_value(k);
        else if (cmt_vld && cmt.idx == MY_IDX) val <= cmt.data;
      end
      assign reg_flat[k*DATA_W +: DATA_W] = val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= bank_hit;
      if (bank_hit) begin
        wr_idx  <= cmt.idx;
        wr_data <= cmt.data;
      end
    end
  end
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
  import ctl3w_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BASE_IDX = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_din,
  input  logic                       ser_bclk,
  input  logic                       ser_latch_n,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat,
  output logic                       wr_stb,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [DATA_W-1:0]          wr_data
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  // Lane order: 2 = framing line, 1 = bit clock, 0 = data.
  logic [2:0] s_lvl, s_rise, s_fall;
  logic       din_s, bclk_rise, latch_lvl, latch_rise, latch_fall;
  logic       cmt_vld;
  wr_cmd_t    cmt;
  logic [CNT_W-1:0] bit_cnt;
  logic       unused_sync;

  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_latch_n, ser_bclk, ser_din}),
    .lvl      (s_lvl),
    .rise     (s_rise),
    .fall     (s_fall)
  );

  assign din_s      = s_lvl[0];
  assign bclk_rise  = s_rise[1];
  assign latch_lvl  = s_lvl[2];
  assign latch_rise = s_rise[2];
  assign latch_fall = s_fall[2];
  assign unused_sync = ^{s_rise[0], s_fall[1:0], s_lvl[1]};

  ctl3w_deframe #(.CNT_W(CNT_W)) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .din_s      (din_s),
    .bclk_rise  (bclk_rise),
    .latch_lvl  (latch_lvl),
    .latch_fall (latch_fall),
    .latch_rise (latch_rise),
    .cmt_vld    (cmt_vld),
    .cmt        (cmt),
    .bit_cnt    (bit_cnt)
  );

  ctl3w_regbank #(.NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmt_vld  (cmt_vld),
    .cmt      (cmt),
    .reg_flat (reg_flat),
    .wr_stb   (wr_stb),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );
endmodule

// File: rtl/ctl3w_port_chk.sv
module ctl3w_port_chk
  import ctl3w_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BASE_IDX = 16,
  parameter int CNT_W    = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_stb,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NUM_REGS*DATA_W-1:0] reg_flat,
  input logic                       cmt_vld,
  input wr_cmd_t                    cmt,
  input logic                       latch_rise,
  input logic [CNT_W-1:0]           bit_cnt
);
  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R8
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(wr_idx) && $stable(wr_data)));

  // R7
  stb_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> idx_hit(wr_idx, BASE_IDX, NUM_REGS));

  // R3
  commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_vld && idx_hit(cmt.idx, BASE_IDX, NUM_REGS))
      |=> (wr_stb && wr_idx == $past(cmt.idx) && wr_data == $past(cmt.data)));

  // R10
  quiet_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_flat) |-> wr_stb);

  // R4
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise && int'(bit_cnt) != FRAME_BITS) |=> !cmt_vld);
endmodule

bind ctl3w_port ctl3w_port_chk #(
  .NUM_REGS (NUM_REGS),
  .BASE_IDX (BASE_IDX),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .reg_flat   (reg_flat),
  .cmt_vld    (cmt_vld),
  .cmt        (cmt),
  .latch_rise (latch_rise),
  .bit_cnt    (bit_cnt)
);

// File: tb/ctl3w_port_bench.sv
module ctl3w_port_bench;
  localparam int NREG = 8;
  localparam int BASE = 16;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_din = 1'b0, ser_bclk = 1'b0, ser_latch_n = 1'b1;
  logic [NREG*8-1:0] reg_flat;
  logic wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;

  int checks = 0;
  int fails = 0;
  int stb_count = 0;
  int stb_wide = 0;
  logic stb_prev = 1'b0;
  logic [7:0] exp_reg [NREG];
  logic [6:0] exp_idx = '0;
  logic [7:0] exp_data = '0;
  int exp_stb = 0;

  always #4 clk = ~clk;

  ctl3w_port #(.NUM_REGS(NREG), .BASE_IDX(BASE)) u_ctl3w_port (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_bclk(ser_bclk),
    .ser_latch_n(ser_latch_n), .reg_flat(reg_flat), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (rst_n && wr_stb) stb_count++;
    if (rst_n && wr_stb && stb_prev) stb_wide++;
    stb_prev <= wr_stb;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NREG; k++) chk(req, 32'(reg_flat[k*8 +: 8]), 32'(exp_reg[k]));
    chk(req, 32'(stb_count), 32'(exp_stb));
    chk(req, 32'(wr_idx), 32'(exp_idx));
    chk(req, 32'(wr_data), 32'(exp_data));
    chk(req, 32'(stb_wide), 32'd0);
  endtask

  task automatic send_bits(input int n, input logic [31:0] w);
    ser_latch_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = w[i];
      wait_clk(HALF);
      ser_bclk = 1'b1;
      wait_clk(HALF);
      ser_bclk = 1'b0;
    end
    wait_clk(HALF);
    ser_latch_n = 1'b1;
  endtask

  function automatic logic [15:0] mk(input logic lead, input logic [6:0] idx, input logic [7:0] d);
    return {lead, idx, d};
  endfunction

  task automatic model_write(input logic [6:0] idx, input logic [7:0] d);
    if (idx >= 7'(BASE) && idx <= 7'(BASE + NREG - 1)) begin
      exp_reg[idx - 7'(BASE)] = d;
      exp_idx = idx;
      exp_data = d;
      exp_stb++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    v = 8'h40;
    for (int k = 0; k < NREG; k++) begin
      exp_reg[k] = v;
      v = v + 8'd3;
    end
    check_all("R1");
    chk("R1", 32'(wr_stb), 32'd0);
  endtask

  // R2, R3, R10: accepted write; checked exactly 8 cycles after the commit edge.
  task automatic t_write(input logic [6:0] idx, input logic [7:0] d);
    send_bits(16, 32'(mk(1'b0, idx, d)));
    model_write(idx, d);
    wait_clk(8);
    check_all("R2/R3/R10");
  endtask

  task automatic t_short;
    send_bits(15, 32'(mk(1'b0, 7'(BASE + 1), 8'h11) >> 1));
    wait_clk(10);
    check_all("R4");
  endtask

  task automatic t_long;
    // The last 16 of these 17 bits form a valid word for index BASE+2.
    send_bits(17, {15'd0, 1'b0, mk(1'b0, 7'(BASE + 2), 8'h77)});
    wait_clk(10);
    check_all("R5");
  endtask

  task automatic t_lead;
    send_bits(16, 32'(mk(1'b1, 7'(BASE + 3), 8'h99)));
    wait_clk(10);
    check_all("R6");
  endtask

  task automatic t_range(input logic [6:0] idx);
    send_bits(16, 32'(mk(1'b0, idx, 8'hEE)));
    wait_clk(10);
    check_all("R7");
  endtask

  task automatic t_stray;
    for (int i = 0; i < 20; i++) begin
      ser_din = i[0];
      wait_clk(HALF);
      ser_bclk = 1'b1;
      wait_clk(HALF);
      ser_bclk = 1'b0;
    end
    wait_clk(10);
    check_all("R9");
    t_write(7'(BASE + 6), 8'h3C);
    chk("R9", 32'(reg_flat[6*8 +: 8]), 32'h3C);
  endtask

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write(7'(BASE), 8'hA5);
    t_write(7'(BASE + NREG - 1), 8'hFF);
    t_write(7'(BASE + 4), 8'h00);
    t_short();
    t_write(7'(BASE + 1), 8'h5A);
    t_long();
    t_lead();
    t_range(7'(BASE - 1));
    t_range(7'(BASE + NREG));
    t_range(7'h7F);
    t_stray();
    t_write(7'(BASE), 8'h81);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule